// File: doc/BRIEF.md
# DTMF Period-Counting Tone Decoder

This block turns a dual-tone keypad signal into a 4-bit key code. It does not process analog samples. It receives two logic-level square waves that upstream band-split filters and zero-crossing comparators have already produced: one carries the row (low-group) tone and the other carries the column (high-group) tone. Each wave is synchronised to the system clock. Its period between successive rising edges is counted in system-clock cycles, and the count is compared against four compile-time count windows to select a frequency bin.

When both groups report the same legal bin on two periods in a row, the block raises `tone_valid` and loads the key code for that row/column pair. When `col4_block` is high, any pair in the fourth column is refused. When either group falls silent for longer than its slowest bin plus a margin, that group loses its indication and `tone_valid` drops. The key code keeps its last value until a new valid pair arrives.

Top module: `dtmf_period_decoder`

## Requirements
- R1: A row tone of 697/770/852/941 Hz paired with a column tone of 1209/1336/1477/1633 Hz raises `tone_valid` when each frequency lies within ±1.5% of its nominal value. `CLK_HZ` sets the clock that measures the periods.
- R2: A tone whose frequency is 3.5% or more above or below every nominal value of its group does not raise `tone_valid`. Each window boundary sits at ±2.5% of the nominal frequency.
- R3: While `tone_valid` is high, `digit_code` holds the key code. Keys 1..9 give 0001..1001, 0 gives 1010, * gives 1011 and # gives 1100. Fourth-column keys give 1101 on the 697 Hz row, 1110 on 770 Hz, 1111 on 852 Hz and 0000 on 941 Hz. Keys 1,2,3 sit on the 697 Hz row, 4,5,6 on 770 Hz, 7,8,9 on 852 Hz, and *,0,# on 941 Hz, in column order 1209/1336/1477 Hz.
- R4: While `col4_block` is high, a pair that uses the 1633 Hz column never raises `tone_valid`. Pairs in the other three columns are accepted as usual.
- R5: A group counts as present only after two consecutive measured periods fall in the same bin. A tone that lasts for only one full row period is never reported.
- R6: `digit_code` changes only in a cycle where `tone_valid` is high. A rejected, inhibited or vanished tone leaves the previous code in place.
- R7: A group input with no rising edge for `TMO` cycles clears that group's indication. `TMO` is the slowest bin's upper window bound plus 1/16 of that bound plus 2. `tone_valid` then falls.
- R8: After reset, `tone_valid` is 0 and `digit_code` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominal rate `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| low_sq | input | 1 | Squared row-group tone, asynchronous |
| high_sq | input | 1 | Squared column-group tone, asynchronous |
| col4_block | input | 1 | High refuses 1633 Hz column pairs |
| digit_code | output | 4 | Registered key code of the last valid pair |
| tone_valid | output | 1 | Registered: a legal, confirmed pair is present |

## Verification
The bench drives tones at exactly ±1.5% and ±3.6% of each nominal frequency. A window drawn at the wrong point would either refuse an in-tolerance key or accept an off-frequency one. It plays all sixteen keys, so a wrong row/column mapping shows up as a wrong code. A decoder that fires on the first period is caught by a tone lasting only one row period. It also checks that the code is held through an inhibited fourth-column key and through silence on one group alone. A design that updates the code on any classification, or never times out a silent group, would show a changed code or a `tone_valid` that stays high.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  typedef logic [1:0] bin_t;

  // nominal bin frequency in Hz; grp 0 = row group, grp 1 = column group
  function automatic int unsigned bin_freq(input int unsigned grp, input int unsigned idx);
    int unsigned f;
    if (grp == 0) begin
      case (idx)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (idx)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // shortest accepted period: frequency 2.5% above nominal, rounded up
  function automatic int unsigned win_lo(input longint unsigned clk_hz, input int unsigned f);
    longint unsigned num, den;
    num = clk_hz * 40;
    den = longint'(f) * 41;
    return int'((num + den - 1) / den);
  endfunction

  // longest accepted period: frequency 2.5% below nominal, rounded down
  function automatic int unsigned win_hi(input longint unsigned clk_hz, input int unsigned f);
    return int'((clk_hz * 40) / (longint'(f) * 39));
  endfunction

  // no-edge limit: slowest bin's upper bound plus a 1/16 margin
  function automatic int unsigned silence_limit(input longint unsigned clk_hz, input int unsigned grp);
    int unsigned h;
    h = win_hi(clk_hz, bin_freq(grp, 0));
    return h + h / 16 + 2;
  endfunction

  // key code for a row/column pair
  function automatic logic [3:0] key_code(input bin_t row, input bin_t col);
    logic [3:0] c;
    if (col == 2'd3)
      c = (row == 2'd3) ? 4'd0 : 4'(13 + row);
    else if (row != 2'd3)
      c = 4'(3 * row + col + 1);
    else
      case (col)
        2'd0: c = 4'd11;
        2'd1: c = 4'd10;
        default: c = 4'd12;
      endcase
    return c;
  endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
module dtmf_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sq_in,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], sq_in};
  end

  // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its delayed copy
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/dtmf_group_meter.sv
module dtmf_group_meter
  import dtmf_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 3579545,
  parameter int unsigned     GRP    = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  output logic grp_valid,
  output bin_t grp_bin
);
  localparam int unsigned NBIN = 4;
  localparam int unsigned TMO  = silence_limit(CLK_HZ, GRP);
  localparam int unsigned CW   = $clog2(TMO + 1);

  logic [CW-1:0]   cnt;
  logic            armed;
  logic            last_ok;
  bin_t            last_bin;
  logic [NBIN-1:0] in_win;
  logic            cur_ok;
  bin_t            cur_bin;
  logic            silent;

  for (genvar i = 0; i < NBIN; i++) begin : g_win
    localparam int unsigned LO = win_lo(CLK_HZ, bin_freq(GRP, i));
    localparam int unsigned HI = win_hi(CLK_HZ, bin_freq(GRP, i));
    assign in_win[i] = (cnt >= CW'(LO)) && (cnt <= CW'(HI));
  end

  always_comb begin
    cur_bin = '0;
    for (int i = NBIN - 1; i >= 0; i--)
      if (in_win[i]) cur_bin = bin_t'(i);
  end

  assign cur_ok = |in_win;
  assign silent = armed && (cnt >= CW'(TMO));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      armed     <= 1'b0;
      last_ok   <= 1'b0;
      last_bin  <= '0;
      grp_valid <= 1'b0;
      grp_bin   <= '0;
    end else if (rise) begin
      cnt      <= CW'(1);
      armed    <= 1'b1;
      last_ok  <= armed && cur_ok;
      last_bin <= cur_bin;
      if (armed && cur_ok && last_ok && (cur_bin == last_bin)) begin
        grp_valid <= 1'b1;
        grp_bin   <= cur_bin;
      end else begin
        grp_valid <= 1'b0;
      end
    end else if (silent) begin
      cnt       <= '0;
      armed     <= 1'b0;
      last_ok   <= 1'b0;
      grp_valid <= 1'b0;
    end else if (armed) begin
      cnt <= cnt + CW'(1);
    end
  end

  // a group can only become valid on a measured edge
  p_valid_on_edge_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(grp_valid) |-> $past(rise));

  // the period counter never runs past the silence limit
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(TMO));

  // silence clears the group on the next cycle
  p_silence_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (silent && !rise) |=> !grp_valid);

endmodule

// File: rtl/dtmf_period_decoder.sv
module dtmf_period_decoder
  import dtmf_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 3579545,
  parameter int unsigned     SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       low_sq,
  input  logic       high_sq,
  input  logic       col4_block,
  output logic [3:0] digit_code,
  output logic       tone_valid
);
  localparam bin_t LAST_COL = bin_t'(3);

  logic rise_lo, rise_hi;
  logic lo_valid, hi_valid;
  bin_t lo_bin, hi_bin;
  logic pair_ok;

  dtmf_edge_sync #(.STAGES(SYNC_STGS)) u_sync_lo (
    .clk(clk), .rst(rst), .sq_in(low_sq), .rise(rise_lo));
  dtmf_edge_sync #(.STAGES(SYNC_STGS)) u_sync_hi (
    .clk(clk), .rst(rst), .sq_in(high_sq), .rise(rise_hi));

  dtmf_group_meter #(.CLK_HZ(CLK_HZ), .GRP(0)) u_row (
    .clk(clk), .rst(rst), .rise(rise_lo), .grp_valid(lo_valid), .grp_bin(lo_bin));
  dtmf_group_meter #(.CLK_HZ(CLK_HZ), .GRP(1)) u_col (
    .clk(clk), .rst(rst), .rise(rise_hi), .grp_valid(hi_valid), .grp_bin(hi_bin));

  assign pair_ok = lo_valid && hi_valid && !(col4_block && (hi_bin == LAST_COL));

  always_ff @(posedge clk) begin
    if (rst) begin
      tone_valid <= 1'b0;
      digit_code <= 4'd0;
    end else begin
      tone_valid <= pair_ok;
      if (pair_ok) digit_code <= key_code(lo_bin, hi_bin);
    end
  end

  // valid output requires both groups confirmed one cycle earlier
  p_both_groups_r1: assert property (@(posedge clk) disable iff (rst)
    tone_valid |-> $past(lo_valid && hi_valid));

  // inhibited fourth column never reported
  p_col4_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    (tone_valid && $past(col4_block)) |-> ($past(hi_bin) != LAST_COL));

  // code holds whenever the output is not valid
  p_code_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !tone_valid |-> $stable(digit_code));

endmodule

// File: tb/dtmf_period_decoder_tb.sv
module dtmf_period_decoder_tb;
  localparam longint unsigned CLK_HZ = 500000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic low_sq = 1'b0, high_sq = 1'b0, col4_block = 1'b0;
  logic [3:0] digit_code;
  logic tone_valid;

  int checks = 0, errors = 0;
  int lo_per = 0, hi_per = 0, lo_cnt = 0, hi_cnt = 0;
  bit seen_valid = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dtmf_period_decoder #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst(rst), .low_sq(low_sq), .high_sq(high_sq),
    .col4_block(col4_block), .digit_code(digit_code), .tone_valid(tone_valid));

  // square-wave generators, period counted in clock cycles
  always @(negedge clk) begin
    if (lo_per == 0) begin lo_cnt <= 0; low_sq <= 1'b0; end
    else begin
      low_sq <= (lo_cnt < lo_per / 2);
      lo_cnt <= (lo_cnt + 1 >= lo_per) ? 0 : lo_cnt + 1;
    end
    if (hi_per == 0) begin hi_cnt <= 0; high_sq <= 1'b0; end
    else begin
      high_sq <= (hi_cnt < hi_per / 2);
      hi_cnt <= (hi_cnt + 1 >= hi_per) ? 0 : hi_cnt + 1;
    end
    if (tone_valid) seen_valid <= 1'b1;
  end

  function automatic real row_hz(input int r);
    case (r) 0: return 697.0; 1: return 770.0; 2: return 852.0; default: return 941.0; endcase
  endfunction

  function automatic real col_hz(input int c);
    case (c) 0: return 1209.0; 1: return 1336.0; 2: return 1477.0; default: return 1633.0; endcase
  endfunction

  function automatic int per_of(input real f, input real dev);
    return $rtoi(real'(CLK_HZ) / (f * (1.0 + dev)) + 0.5);
  endfunction

  // key code table from R3, indexed row*4+col
  function automatic logic [3:0] exp_code(input int r, input int c);
    case (r * 4 + c)
      0: return 4'b0001;  1: return 4'b0010;  2: return 4'b0011;  3: return 4'b1101;
      4: return 4'b0100;  5: return 4'b0101;  6: return 4'b0110;  7: return 4'b1110;
      8: return 4'b0111;  9: return 4'b1000; 10: return 4'b1001; 11: return 4'b1111;
     12: return 4'b1011; 13: return 4'b1010; 14: return 4'b1100; default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic play(input int r, input int c, input real dl, input real dh, input bit inh);
    col4_block = inh;
    lo_per = per_of(row_hz(r), dl);
    hi_per = per_of(col_hz(c), dh);
    repeat (1800) @(negedge clk);
  endtask

  task automatic quiet();
    lo_per = 0; hi_per = 0;
    repeat (850) @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset valid", tone_valid, 0);
    chk("R8 reset code", digit_code, 0);

    // every key at nominal frequency
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        play(r, c, 0.0, 0.0, 1'b0);
        chk("R1 nominal valid", tone_valid, 1);
        chk("R3 key code", digit_code, exp_code(r, c));
        quiet();
        chk("R6 code held after silence", digit_code, exp_code(r, c));
      end

    // tolerance edges: accepted
    play(0, 3, 0.015, -0.015, 1'b0);
    chk("R1 +1.5/-1.5 valid", tone_valid, 1);
    chk("R3 code A", digit_code, 4'b1101);
    quiet();
    play(3, 0, -0.015, 0.015, 1'b0);
    chk("R1 -1.5/+1.5 valid", tone_valid, 1);
    chk("R3 code *", digit_code, 4'b1011);
    quiet();

    // tolerance edges: rejected, code held
    play(1, 1, 0.036, 0.0, 1'b0);
    chk("R2 row +3.6 rejected", tone_valid, 0);
    chk("R6 code held on reject", digit_code, 4'b1011);
    quiet();
    play(2, 2, 0.0, -0.036, 1'b0);
    chk("R2 col -3.6 rejected", tone_valid, 0);
    quiet();
    play(3, 3, -0.036, 0.0, 1'b0);
    chk("R2 row -3.6 rejected", tone_valid, 0);
    quiet();
    play(0, 0, 0.0, 0.036, 1'b0);
    chk("R2 col +3.6 rejected", tone_valid, 0);
    quiet();

    // fourth column blocked, other columns pass
    play(1, 2, 0.0, 0.0, 1'b1);
    chk("R4 col3 passes with block", tone_valid, 1);
    chk("R4 col3 code", digit_code, 4'b0110);
    quiet();
    play(1, 3, 0.0, 0.0, 1'b1);
    chk("R4 col4 blocked", tone_valid, 0);
    chk("R6 code held on block", digit_code, 4'b0110);
    quiet();
    col4_block = 1'b0;

    // a single row period must not be reported
    seen_valid = 1'b0;
    lo_per = per_of(row_hz(2), 0.0);
    hi_per = per_of(col_hz(1), 0.0);
    repeat (lo_per + lo_per / 2) @(negedge clk);
    lo_per = 0; hi_per = 0;
    repeat (850) @(negedge clk);
    chk("R5 one period not reported", seen_valid, 0);
    chk("R6 code after short tone", digit_code, 4'b0110);

    // column tone disappears while row continues
    play(2, 0, 0.0, 0.0, 1'b0);
    chk("R1 key 7 valid", tone_valid, 1);
    hi_per = 0;
    repeat (900) @(negedge clk);
    chk("R7 silent column clears valid", tone_valid, 0);
    chk("R6 code held after timeout", digit_code, 4'b0111);
    quiet();

    // random keys within tolerance
    for (int k = 0; k < 8; k++) begin
      int r, c;
      real dl, dh;
      r = int'($urandom % 4);
      c = int'($urandom % 4);
      dl = (real'(int'($urandom % 301)) - 150.0) / 10000.0;
      dh = (real'(int'($urandom % 301)) - 150.0) / 10000.0;
      held = digit_code;
      play(r, c, dl, dh, 1'b0);
      chk("R1 random valid", tone_valid, 1);
      chk("R3 random code", digit_code, exp_code(r, c));
      quiet();
    end

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule